// File: doc/BRIEF.md
# Four-Phase Asynchronous Write Handshake

This block moves one data word per transfer from a sender to a receiver that run on unrelated clocks. The two sides share no timing reference. They agree on when the word is valid through two control lines. The sender raises a request line and the receiver raises an acknowledge line. Both lines then return to zero before the next word may go. Each transfer therefore lasts as long as the receiver needs, and the same logic serves fast and slow receivers.

The sender side takes a start pulse and a word from its local user. It drives the word onto the shared data lines first and raises the request one clock later. It then waits for the acknowledge, withdraws the request and the word, and waits for the acknowledge to fall. At that point it gives its user a one-cycle completion pulse. A cycle counter flags an error if the acknowledge is slow to come.

The receiver side waits for the request and then for its local sink to be ready. It captures the word, shows it to the sink with a one-cycle valid pulse, and raises the acknowledge. It drops the acknowledge once the request has gone low. Each side sees the other side's control line only through a two-flop synchronizer.

Top module: `hs4_write_link`

## Requirements
- R1: After synchronous active-low reset, `bus_req`, `bus_ack`, `m_busy`, `m_done`, `m_timeout` and `s_rvalid` are 0, and `bus_data` is all zeros.
- R2: The word taken with `m_start` is present on `bus_data` in the sender clock cycle before `bus_req` rises. `bus_req` is low in that cycle.
- R3: The receiver captures `bus_data` only while the request is seen high. It does so when `s_accept` is high, then pulses `s_rvalid` for one `s_clk` cycle with `s_rdata` equal to the sent word, and raises `bus_ack`. There is exactly one capture per transfer.
- R4: After the sender sees the acknowledge high, it drops `bus_req` and returns `bus_data` to all zeros.
- R5: After the receiver sees the request low, it drops `bus_ack`, so both lines are low when the transfer completes.
- R6: `m_start` is ignored while `m_busy` is high or while the synchronized acknowledge is still high. An ignored start causes no capture and queues no later transfer.
- R7: `m_done` pulses for exactly one `m_clk` cycle per transfer, once the acknowledge is seen low again. `m_busy` is 0 in the following cycle.
- R8: `m_timeout` goes high if the acknowledge has not been seen within `TIMEOUT_CYC` sender cycles of `bus_req` rising. It stays high until the next accepted start clears it. The transfer still completes normally.
- R9: The transfer length follows the receiver. Holding `s_accept` low for longer makes the start-to-done time longer by about that delay.
- R10: `bus_data` stays unchanged from the cycle before `bus_req` rises until the sender has seen the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_clk | input | 1 | Sender clock |
| m_rst_n | input | 1 | Sender synchronous active-low reset |
| m_start | input | 1 | Request to send `m_wdata` (taken when idle) |
| m_wdata | input | DATA_W | Word to send |
| m_busy | output | 1 | Transfer in progress |
| m_done | output | 1 | One-cycle completion pulse |
| m_timeout | output | 1 | Acknowledge later than TIMEOUT_CYC cycles |
| s_clk | input | 1 | Receiver clock |
| s_rst_n | input | 1 | Receiver synchronous active-low reset |
| s_accept | input | 1 | Local sink ready to take a word |
| s_rdata | output | DATA_W | Captured word |
| s_rvalid | output | 1 | One-cycle pulse: `s_rdata` is new |
| bus_req | output | 1 | Request line, sender to receiver |
| bus_ack | output | 1 | Acknowledge line, receiver to sender |
| bus_data | output | DATA_W | Shared data lines (zero when not driven) |

## Verification
The assertions assume two things about the clocks. Both clocks run, and each side holds its reset long enough for that side's synchronizer to clear. The receiver-side capture checks assume the sender keeps the word steady while the request is high, which the sender-side assertions check in turn. The stimulus uses two unrelated clock periods. It presents starts only from the sender's idle state, except in directed cases that deliberately pulse `m_start` mid-transfer. The behavioural receiver always drives `s_accept` as a clean level after seeing the request.

// File: rtl/hs4_pkg.sv
// Package hs4_pkg
// Shared state encodings for the four-phase write handshake.
// Assumes: nothing beyond standard SystemVerilog enums.
package hs4_pkg;

    typedef enum logic [1:0] {
        MST_IDLE  = 2'd0,
        MST_SETUP = 2'd1,
        MST_REQ   = 2'd2,
        MST_RTZ   = 2'd3
    } mst_state_t;

    typedef enum logic [1:0] {
        SLV_IDLE = 2'd0,
        SLV_WAIT = 2'd1,
        SLV_ACK  = 2'd2
    } slv_state_t;

endpackage

// File: rtl/hs4_sync.sv
// Module hs4_sync
// Multi-flop synchronizer for a single level signal from a foreign clock.
// Assumes: STAGES >= 2 and the input is a glitch-free registered level.
module hs4_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    // Purpose: shift the foreign level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/hs4_sender.sv
// Module hs4_sender
// Sender-side FSM: drives the word, then the request, waits for the
// acknowledge, withdraws both, waits for return to zero, pulses done.
// Also counts request-high cycles and flags a late acknowledge.
// Assumes: ack_async is a registered level from the receiver clock domain.
module hs4_sender
    import hs4_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int TIMEOUT_CYC = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack_async,
    output logic              req,
    output logic [DATA_W-1:0] bus_data,
    output logic              busy,
    output logic              done,
    output logic              timeout
);

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(TIMEOUT_CYC);

    mst_state_t        state_q;
    logic              ack_s;
    logic [CNT_W-1:0]  wait_cnt_q;

    hs4_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ack_async),
        .q_sync  (ack_s)
    );

    // Purpose: four-edge sequencing, data/request drive, done and timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= MST_IDLE;
            req        <= 1'b0;
            bus_data   <= '0;
            done       <= 1'b0;
            timeout    <= 1'b0;
            wait_cnt_q <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                MST_IDLE: begin
                    if (start && !ack_s) begin
                        bus_data   <= wdata;
                        timeout    <= 1'b0;
                        wait_cnt_q <= '0;
                        state_q    <= MST_SETUP;
                    end
                end
                MST_SETUP: begin
                    req     <= 1'b1;
                    state_q <= MST_REQ;
                end
                MST_REQ: begin
                    if (ack_s) begin
                        req      <= 1'b0;
                        bus_data <= '0;
                        state_q  <= MST_RTZ;
                    end else begin
                        if (wait_cnt_q != CNT_SAT) begin
                            wait_cnt_q <= wait_cnt_q + 1'b1;
                        end
                        if (wait_cnt_q == CNT_LAST) begin
                            timeout <= 1'b1;
                        end
                    end
                end
                MST_RTZ: begin
                    if (!ack_s) begin
                        done    <= 1'b1;
                        state_q <= MST_IDLE;
                    end
                end
                default: state_q <= MST_IDLE;
            endcase
        end
    end

    assign busy = (state_q != MST_IDLE);

    // R2: word already on the lines in the cycle before the request rises
    p_data_before_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $stable(bus_data));

    // R10: word held while the request is high
    p_data_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req && $past(req)) |-> $stable(bus_data));

    // R4: the request only falls after the acknowledge was seen
    p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> $past(ack_s));

    // R6: a transfer only starts with the acknowledge seen low
    p_start_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(ack_s));

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the error flag can only rise while waiting on the request
    p_timeout_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> $past(req));

endmodule

// File: rtl/hs4_receiver.sv
// Module hs4_receiver
// Receiver-side FSM: on a seen request and a ready sink, captures the word,
// pulses valid and raises the acknowledge; drops it once the request is low.
// Assumes: the sender holds bus_data steady while its request is high.
module hs4_receiver
    import hs4_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_async,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              accept,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    slv_state_t state_q;
    logic       req_s;

    hs4_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (req_async),
        .q_sync  (req_s)
    );

    // Purpose: capture on request plus sink-ready, then run return to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLV_IDLE;
            ack     <= 1'b0;
            rdata   <= '0;
            rvalid  <= 1'b0;
        end else begin
            rvalid <= 1'b0;
            case (state_q)
                SLV_IDLE: begin
                    if (req_s) begin
                        state_q <= SLV_WAIT;
                    end
                end
                SLV_WAIT: begin
                    if (accept && req_s) begin
                        rdata   <= bus_data;
                        rvalid  <= 1'b1;
                        ack     <= 1'b1;
                        state_q <= SLV_ACK;
                    end
                end
                SLV_ACK: begin
                    if (!req_s) begin
                        ack     <= 1'b0;
                        state_q <= SLV_IDLE;
                    end
                end
                default: state_q <= SLV_IDLE;
            endcase
        end
    end

    // R3: a capture only happens while the request is seen high
    p_capture_in_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(req_s));

    // R3: the acknowledge rises together with the capture pulse
    p_ack_with_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> rvalid);

    // R3: the valid pulse lasts one cycle
    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

    // R5: the acknowledge only falls after the request was seen low
    p_ack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> !$past(req_s));

endmodule

// File: rtl/hs4_write_link.sv
// Module hs4_write_link
// Top: one sender and one receiver joined by request, acknowledge and data
// lines, each side on its own clock and reset.
// Assumes: both clocks run; each reset is held for at least SYNC_STAGES cycles.
module hs4_write_link #(
    parameter int DATA_W      = 16,
    parameter int TIMEOUT_CYC = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              m_clk,
    input  logic              m_rst_n,
    input  logic              m_start,
    input  logic [DATA_W-1:0] m_wdata,
    output logic              m_busy,
    output logic              m_done,
    output logic              m_timeout,
    input  logic              s_clk,
    input  logic              s_rst_n,
    input  logic              s_accept,
    output logic [DATA_W-1:0] s_rdata,
    output logic              s_rvalid,
    output logic              bus_req,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_data
);

    hs4_sender #(
        .DATA_W      (DATA_W),
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sender (
        .clk       (m_clk),
        .rst_n     (m_rst_n),
        .start     (m_start),
        .wdata     (m_wdata),
        .ack_async (bus_ack),
        .req       (bus_req),
        .bus_data  (bus_data),
        .busy      (m_busy),
        .done      (m_done),
        .timeout   (m_timeout)
    );

    hs4_receiver #(
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_receiver (
        .clk       (s_clk),
        .rst_n     (s_rst_n),
        .req_async (bus_req),
        .bus_data  (bus_data),
        .accept    (s_accept),
        .ack       (bus_ack),
        .rdata     (s_rdata),
        .rvalid    (s_rvalid)
    );

endmodule

// File: tb/test_hs4_write_link.sv
module test_hs4_write_link;

    localparam int CLK_PERIOD   = 10;
    localparam int S_CLK_PERIOD = 14;
    localparam int DATA_W       = 16;
    localparam int TIMEOUT_CYC  = 64;

    logic              m_clk = 1'b0;
    logic              s_clk = 1'b0;
    logic              m_rst_n = 1'b0;
    logic              s_rst_n = 1'b0;
    logic              m_start = 1'b0;
    logic [DATA_W-1:0] m_wdata = '0;
    logic              s_accept = 1'b0;
    logic              m_busy, m_done, m_timeout;
    logic [DATA_W-1:0] s_rdata;
    logic              s_rvalid;
    logic              bus_req, bus_ack;
    logic [DATA_W-1:0] bus_data;

    hs4_write_link #(
        .DATA_W      (DATA_W),
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .SYNC_STAGES (2)
    ) i_hs4_write_link (
        .m_clk     (m_clk),
        .m_rst_n   (m_rst_n),
        .m_start   (m_start),
        .m_wdata   (m_wdata),
        .m_busy    (m_busy),
        .m_done    (m_done),
        .m_timeout (m_timeout),
        .s_clk     (s_clk),
        .s_rst_n   (s_rst_n),
        .s_accept  (s_accept),
        .s_rdata   (s_rdata),
        .s_rvalid  (s_rvalid),
        .bus_req   (bus_req),
        .bus_ack   (bus_ack),
        .bus_data  (bus_data)
    );

    always #(CLK_PERIOD/2)   m_clk = ~m_clk;
    always #(S_CLK_PERIOD/2) s_clk = ~s_clk;

    int                n_tests = 0;
    int                n_fail  = 0;
    int                slv_delay = 0;
    int                vcount = 0;
    logic [DATA_W-1:0] last_rdata = '0;
    logic [DATA_W-1:0] exp_word = '0;
    logic [DATA_W-1:0] pre_data = '0;
    logic              pre_req = 1'b0;
    bit                finished = 1'b0;

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // Expected timeout flag: receiver delay well past the sender's limit
    function automatic bit exp_timeout(input int delay);
        return (delay * S_CLK_PERIOD) > ((TIMEOUT_CYC + 8) * CLK_PERIOD);
    endfunction

    // Capture monitor (receiver side, sampled away from the edge)
    always @(negedge s_clk) begin
        if (s_rst_n && s_rvalid) begin
            vcount++;
            last_rdata = s_rdata;
        end
    end

    // Line values one sender cycle back, for the R2 check
    always @(negedge m_clk) begin
        pre_data = bus_data;
        pre_req  = bus_req;
    end

    // R2: word on the lines, request low, in the cycle before the rise
    always @(posedge bus_req) begin
        check(pre_req == 1'b0 && pre_data == exp_word, "R2", longint'(pre_data), longint'(exp_word));
    end

    // Behavioural receiver sink with configurable response delay
    initial begin
        forever begin
            @(posedge s_clk iff bus_req);
            repeat (slv_delay) @(posedge s_clk);
            @(negedge s_clk) s_accept = 1'b1;
            @(posedge s_clk iff bus_ack);
            @(negedge s_clk) s_accept = 1'b0;
            wait (bus_req == 1'b0);
        end
    end

    task automatic run_xfer(input logic [DATA_W-1:0] word, input int delay,
                            input bit extra_start, output int cyc);
        int v0;
        v0        = vcount;
        exp_word  = word;
        slv_delay = delay;
        @(negedge m_clk);
        m_start = 1'b1;
        m_wdata = word;
        @(negedge m_clk);
        m_start = 1'b0;
        cyc = 1;
        if (extra_start) begin
            // R6: start pulses during a busy transfer are ignored
            m_start = 1'b1;
            m_wdata = ~word;
            @(negedge m_clk);
            m_start = 1'b0;
            @(negedge m_clk);
            cyc += 2;
        end
        while (!m_done) begin
            @(negedge m_clk);
            cyc++;
        end
        check(bus_req == 1'b0, "R4", longint'(bus_req), 0);
        check(bus_data == '0, "R4", longint'(bus_data), 0);
        check(bus_ack == 1'b0, "R5", longint'(bus_ack), 0);
        check(vcount == v0 + 1, "R3", longint'(vcount - v0), 1);
        check(last_rdata == word, "R3", longint'(last_rdata), longint'(word));
        check(m_timeout == exp_timeout(delay), "R8", longint'(m_timeout), longint'(exp_timeout(delay)));
        @(negedge m_clk);
        check(m_done == 1'b0, "R7", longint'(m_done), 0);
        check(m_busy == 1'b0, "R7", longint'(m_busy), 0);
        if (extra_start) begin
            repeat (6) @(negedge m_clk);
            check(m_busy == 1'b0 && vcount == v0 + 1, "R6", longint'(vcount - v0), 1);
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge m_clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int c_fast, c_slow, c_tmp;
        void'($urandom(32'd2024));
        repeat (6) @(posedge s_clk);
        @(negedge m_clk);
        m_rst_n = 1'b1;
        s_rst_n = 1'b1;
        @(negedge m_clk);
        // R1: reset state
        check(bus_req == 1'b0 && bus_ack == 1'b0, "R1", longint'({bus_req, bus_ack}), 0);
        check(m_busy == 1'b0 && m_done == 1'b0 && m_timeout == 1'b0, "R1",
              longint'({m_busy, m_done, m_timeout}), 0);
        check(s_rvalid == 1'b0 && bus_data == '0, "R1", longint'(bus_data), 0);

        // Directed: fast and slow receivers (R9)
        run_xfer(16'hA5C3, 0, 1'b0, c_fast);
        run_xfer(16'h0000, 20, 1'b0, c_slow);
        check(c_slow > c_fast + 15, "R9", longint'(c_slow), longint'(c_fast + 16));

        // Directed: all-ones word with an ignored start mid-transfer (R6)
        run_xfer(16'hFFFF, 3, 1'b1, c_tmp);

        // Directed: late acknowledge sets the flag (R8), next start clears it
        run_xfer(16'h1234, 120, 1'b0, c_tmp);
        check(m_timeout == 1'b1, "R8", longint'(m_timeout), 1);
        run_xfer(16'h4321, 1, 1'b0, c_tmp);
        check(m_timeout == 1'b0, "R8", longint'(m_timeout), 0);

        // Random words and receiver delays; R10 covered by data checks
        for (int i = 0; i < 20; i++) begin
            run_xfer(DATA_W'($urandom), int'($urandom % 9), ($urandom % 4) == 0, c_tmp);
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule